// File: doc/BRIEF.md
# Folded Symmetric Complex FIR Filter

This block low-pass filters a stream of complex samples with a 97-tap linear-phase FIR response. The in-phase and quadrature parts travel through two identical real datapaths that use one fixed coefficient set. Samples arrive no faster than one per initiation interval (II) clock cycles. Each datapath therefore reuses a small bank of multipliers over those cycles instead of building one multiplier per tap.

Linear phase makes the coefficients mirror-symmetric. Taps p and 96−p are summed first and then multiplied once by their common coefficient, which leaves 48 products per rail. The centre tap has a weight of exactly one, so its sample is added to the accumulator without a multiplier. With II = 10 each rail uses ceil(48/10) = 5 multipliers, and with II = 8 it uses 6. A slot whose pair index passes 47 contributes zero. The full-precision sum is rounded and saturated back to the sample width. A one-cycle valid pulse marks each result.

Top module: `cfir_fold`

## Requirements
- R1: While reset is held and just after it is released, out_valid is 0 and out_re and out_im are 0. The sample history is all zero, so outputs that are formed before 97 samples have been accepted treat the missing older samples as zero.
- R2: Each rail computes y = sat(round(x[48]·2^17 + Σ_{p=0..47} c(p)·(x[p] + x[96−p]))), bit-exact. Here x[0] is the sample just accepted and x[k] is the one accepted k inputs earlier. The real and imaginary rails use the same c(p) and do not interact.
- R3: The 18-bit signed coefficient shared by taps p and 96−p is c(p) = (((53·p + 7) mod 97) − 48) · 1021, for p = 0..47.
- R4: The centre tap x[48] is weighted by exactly 1.0 in a Q1.17 format, so it enters the sum as x[48]·2^17.
- R5: Rounding adds 2^16 to the full sum and then shifts it arithmetically right by 17, which rounds halves toward plus infinity.
- R6: The rounded value saturates to the range −32768..32767.
- R7: An input accepted at clock edge n yields out_valid high for exactly one cycle, starting at edge n + II + 1. Each accepted input gives exactly one pulse.
- R8: The history advances only on a cycle with in_valid high. Idle cycles between inputs, of any length, do not change the results.
- R9: out_re and out_im hold their values in every cycle where out_valid is low.
- R10: Accepted inputs must be at least II cycles apart. Shorter spacing is outside the contract.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Qualifies in_re/in_im for one cycle |
| in_re | input | 16 | In-phase sample, signed |
| in_im | input | 16 | Quadrature sample, signed |
| out_valid | output | 1 | One-cycle pulse marking a filtered result |
| out_re | output | 16 | Filtered in-phase result, signed |
| out_im | output | 16 | Filtered quadrature result, signed |

## Verification
Faults in the history, the pair indexing or the coefficient selection show up as wrong output values. An impulse makes each coefficient appear on its own output, so such a fault is visible within the first 97 outputs after the impulse. A fault in the slot sequencing or the accumulator clear corrupts every result from the first pulse on. A wrong latency or a missing pulse is flagged in the same cycle it happens, because out_valid is compared with the expected schedule on every clock. Rounding and saturation faults appear as soon as random or full-scale inputs drive the sum across a half-LSB boundary or past the 16-bit range.

// File: rtl/cfir_pkg.sv
package cfir_pkg;
  localparam int TAPS  = 97;
  localparam int PAIRS = (TAPS - 1) / 2;
  localparam int CTR   = PAIRS;
  localparam int DW    = 16;
  localparam int CW    = 18;
  localparam int FRAC  = 17;
  localparam int PW    = DW + 1 + CW;
  localparam int ACCW  = PW + $clog2(PAIRS + 1) + 1;

  function automatic logic [PAIRS*CW-1:0] coef_table();
    logic [PAIRS*CW-1:0] t;
    int v;
    t = '0;
    for (int p = 0; p < PAIRS; p++) begin
      v = (((53 * p + 7) % 97) - 48) * 1021;
      t[p*CW +: CW] = CW'(v);
    end
    return t;
  endfunction

  localparam logic [PAIRS*CW-1:0] COEFS = coef_table();
endpackage

// File: rtl/cfir_tapline.sv
module cfir_tapline #(
  parameter int N = 97,
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift,
  input  logic [W-1:0]   din,
  output logic [N*W-1:0] taps
);
  logic [N*W-1:0] taps_d;

  always_comb begin
    taps_d = taps;
    if (shift) taps_d = {taps[(N-1)*W-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) taps <= '0;
    else        taps <= taps_d;
  end
endmodule

// File: rtl/cfir_seq.sv
module cfir_seq #(
  parameter int II = 10,
  localparam int CNTW = (II > 1) ? $clog2(II) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            busy,
  output logic [CNTW-1:0] cnt
);
  logic            busy_d;
  logic [CNTW-1:0] cnt_d;

  always_comb begin
    busy_d = busy;
    cnt_d  = cnt;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy) begin
      if (cnt == CNTW'(II - 1)) busy_d = 1'b0;
      else                      cnt_d  = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else begin
      busy <= busy_d;
      cnt  <= cnt_d;
    end
  end
endmodule

// File: rtl/cfir_rail.sv
module cfir_rail import cfir_pkg::*; #(
  parameter int II = 10,
  localparam int CNTW = (II > 1) ? $clog2(II) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TAPS*DW-1:0]   taps,
  input  logic                 busy,
  input  logic [CNTW-1:0]      cnt,
  output logic signed [DW-1:0] y,
  output logic                 y_valid
);
  localparam int M = (PAIRS + II - 1) / II;
  localparam logic signed [ACCW-1:0] YMAX = ACCW'((1 << (DW - 1)) - 1);
  localparam logic signed [ACCW-1:0] YMIN = -YMAX - 1;
  localparam logic signed [ACCW-1:0] HALF = ACCW'(1) <<< (FRAC - 1);

  logic signed [PW-1:0] prod [M];

  // one pre-adder and multiplier per slot; slot m handles pair cnt*M+m
  for (genvar m = 0; m < M; m++) begin : g_mul
    int                   pidx;
    int                   ps;
    logic signed [DW-1:0] a, b;
    logic signed [DW:0]   pre;
    logic signed [CW-1:0] cf;
    assign pidx = int'(cnt) * M + m;
    assign ps   = (pidx < PAIRS) ? pidx : 0;
    assign a    = taps[ps*DW +: DW];
    assign b    = taps[(TAPS-1-ps)*DW +: DW];
    assign pre  = (DW+1)'(a) + (DW+1)'(b);
    assign cf   = COEFS[ps*CW +: CW];
    assign prod[m] = (pidx < PAIRS) ? (PW'(pre) * PW'(cf)) : '0;
  end

  logic signed [ACCW-1:0] psum_d, psum_q, acc_d, acc_q, rnd, shr, cterm;
  logic signed [DW-1:0]   centre, y_d;
  logic                   first_d, last_d, first_q, last_q, vld_q;

  always_comb begin
    psum_d = '0;
    for (int m = 0; m < M; m++) psum_d = psum_d + ACCW'(prod[m]);
    first_d = busy && (cnt == '0);
    last_d  = busy && (cnt == CNTW'(II - 1));
    centre  = taps[CTR*DW +: DW];
    cterm   = ACCW'(centre) <<< FRAC;
    acc_d   = (first_q ? cterm : acc_q) + psum_q;
    rnd     = acc_d + HALF;
    shr     = rnd >>> FRAC;
    if (shr > YMAX)      y_d = DW'(YMAX);
    else if (shr < YMIN) y_d = DW'(YMIN);
    else                 y_d = DW'(shr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psum_q  <= '0;
      acc_q   <= '0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
      vld_q   <= 1'b0;
      y       <= '0;
      y_valid <= 1'b0;
    end else begin
      first_q <= first_d;
      last_q  <= last_d;
      vld_q   <= busy;
      y_valid <= last_q;
      if (busy)   psum_q <= psum_d;
      if (vld_q)  acc_q  <= acc_d;
      if (last_q) y      <= y_d;
    end
  end
endmodule

// File: rtl/cfir_fold.sv
module cfir_fold import cfir_pkg::*; #(
  parameter int II = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [15:0]   in_re,
  input  logic signed [15:0]   in_im,
  output logic                 out_valid,
  output logic signed [15:0]   out_re,
  output logic signed [15:0]   out_im
);
  localparam int CNTW = (II > 1) ? $clog2(II) : 1;

  logic [1:0]          rs_q;
  logic                rst_i;
  logic                busy;
  logic [CNTW-1:0]     cnt;
  logic [TAPS*DW-1:0]  taps_re, taps_im;
  logic                v_re, v_im;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  cfir_seq #(.II(II)) u_seq (
    .clk(clk), .rst_n(rst_i), .start(in_valid), .busy(busy), .cnt(cnt)
  );

  cfir_tapline #(.N(TAPS), .W(DW)) u_line_re (
    .clk(clk), .rst_n(rst_i), .shift(in_valid), .din(in_re), .taps(taps_re)
  );
  cfir_tapline #(.N(TAPS), .W(DW)) u_line_im (
    .clk(clk), .rst_n(rst_i), .shift(in_valid), .din(in_im), .taps(taps_im)
  );

  cfir_rail #(.II(II)) u_rail_re (
    .clk(clk), .rst_n(rst_i), .taps(taps_re), .busy(busy), .cnt(cnt),
    .y(out_re), .y_valid(v_re)
  );
  cfir_rail #(.II(II)) u_rail_im (
    .clk(clk), .rst_n(rst_i), .taps(taps_im), .busy(busy), .cnt(cnt),
    .y(out_im), .y_valid(v_im)
  );

  assign out_valid = v_re & v_im;
endmodule

// File: rtl/cfir_fold_chk.sv
module cfir_fold_chk #(
  parameter int II = 10
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        out_valid,
  input logic [15:0] out_re,
  input logic [15:0] out_im
);
  logic [II+1:0] hist;
  int            gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
      gap  <= II;
    end else begin
      hist <= {hist[II:0], in_valid};
      if (in_valid)      gap <= 0;
      else if (gap < II) gap <= gap + 1;
    end
  end

  AST_LATENCY:    assert property (@(posedge clk) disable iff (!rst_n) out_valid == hist[II+1]); // R7
  AST_ONE_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) out_valid |=> !out_valid); // R7
  AST_IN_SPACING: assert property (@(posedge clk) disable iff (!rst_n) in_valid |-> gap >= II - 1); // R10
  AST_HOLD_RE:    assert property (@(posedge clk) disable iff (!rst_n) !out_valid |-> $stable(out_re)); // R9
  AST_HOLD_IM:    assert property (@(posedge clk) disable iff (!rst_n) !out_valid |-> $stable(out_im)); // R9
endmodule

bind cfir_fold cfir_fold_chk #(.II(II)) u_chk (.*);

// File: tb/cfir_fold_test.sv
`timescale 1ns/1ps
module cfir_fold_test;
  localparam int II = 10;
  localparam int NT = 97;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [15:0] in_re = '0, in_im = '0;
  logic out_valid;
  logic signed [15:0] out_re, out_im;

  cfir_fold #(.II(II)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int hre[NT], him[NT];
  int due_q[$], ere_q[$], eim_q[$];
  int errors = 0, checks = 0;
  int last_re = 0, last_im = 0;
  string tag = "R1";
  bit running = 0, finished = 0;
  bit [31:0] seed = 32'h1234_5678;

  function automatic int coef(int p);
    return (((53 * p + 7) % 97) - 48) * 1021;
  endfunction

  function automatic int filt(input int h[NT]);
    longint acc;
    acc = longint'(h[48]) * 131072;
    for (int p = 0; p < 48; p++) acc += longint'(coef(p)) * longint'(h[p] + h[96-p]);
    acc = (acc + 65536) >>> 17;
    if (acc > 32767) acc = 32767;
    if (acc < -32768) acc = -32768;
    return int'(acc);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic int rnd16();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 8) & 32'h0000_FFFF) - 32768;
  endfunction

  task automatic send(int re, int im, int gap);
    @(negedge clk);
    in_valid = 1'b1;
    in_re = 16'(re);
    in_im = 16'(im);
    for (int k = NT - 1; k > 0; k--) begin
      hre[k] = hre[k-1];
      him[k] = him[k-1];
    end
    hre[0] = re;
    him[0] = im;
    due_q.push_back(cyc + II + 2);
    ere_q.push_back(filt(hre));
    eim_q.push_back(filt(him));
    @(negedge clk);
    in_valid = 1'b0;
    repeat (gap - 2) @(negedge clk);
  endtask

  // per-cycle comparison against the behavioural schedule
  always @(negedge clk) begin
    bit ev;
    int er, ei, dd;
    if (running && !finished) begin
      ev = (due_q.size() > 0) && (due_q[0] == cyc);
      check(out_valid == ev, "R7", "out_valid", int'(out_valid), int'(ev));
      if (ev) begin
        dd = due_q.pop_front();
        er = ere_q.pop_front();
        ei = eim_q.pop_front();
        check(int'(out_re) == er, tag, "out_re", int'(out_re), er);
        check(int'(out_im) == ei, tag, "out_im", int'(out_im), ei);
        last_re = er;
        last_im = ei;
      end else begin
        check(int'(out_re) == last_re, "R9", "out_re hold", int'(out_re), last_re);
        check(int'(out_im) == last_im, "R9", "out_im hold", int'(out_im), last_im);
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      finish_run();
    end
  end

  initial begin
    for (int k = 0; k < NT; k++) begin
      hre[k] = 0;
      him[k] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: idle outputs after reset
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(out_re == 16'sd0, "R1", "out_re after reset", int'(out_re), 0);
    check(out_im == 16'sd0, "R1", "out_im after reset", int'(out_im), 0);
    running = 1;

    // R3 R4 R1: impulse exposes each coefficient over zero history
    tag = "R3 R4 R1";
    send(16384, -16384, II);
    repeat (100) send(0, 0, II);

    // R2 R5: random full-range data at the densest legal rate
    tag = "R2 R5";
    repeat (200) send(rnd16(), rnd16(), II);

    // R8: irregular idle gaps between inputs
    tag = "R8 R2";
    repeat (120) begin
      int g;
      g = II + int'(seed % 7);
      send(rnd16(), rnd16(), g);
    end

    // R6: full-scale inputs of both signs push the sum past the output range
    tag = "R6";
    repeat (110) send(32767, -32768, II);
    repeat (110) send(-32768, 32767, II);

    repeat (II + 6) @(negedge clk);
    check(due_q.size() == 0, "R7", "outstanding results", due_q.size(), 0);
    finish_run();
  end
endmodule